// File: doc/BRIEF.md
# Rotating Interleaved Shared-Memory Arbiter

This block lets a group of processor cores share one word-addressed memory without a single owner taking turns. The memory is cut into as many banks as there are cores, and the lowest bits of a word address choose the bank. A phase counter advances by one on every clock. In every cycle each core faces a different bank, so a core whose address matches the bank it faces proceeds in that cycle while other cores proceed in other banks at the same moment. A core never waits longer than one full turn of the rotation. How long it waits depends only on its address and on the phase in the cycle it asks.

A core raises its request with the address, the write flag, the write data and the byte enables. It holds all of them steady until it sees its grant. The grant is a single-cycle pulse. A read returns its word one cycle after the grant, marked by a valid strobe. Each core has a small controller with three states. In PORT_IDLE the core has nothing pending. From PORT_IDLE or PORT_RESP, a request that is aligned in the current cycle moves the controller to PORT_RESP if it is a read and to PORT_IDLE if it is a write. A request that is not aligned moves it to PORT_WAIT. PORT_WAIT stays put while the request is held and not aligned. It leaves to PORT_RESP on an aligned read, to PORT_IDLE on an aligned write, and to PORT_IDLE if the request is dropped. PORT_RESP lasts one cycle, drives the valid strobe, and then behaves like PORT_IDLE.

The core count must be a power of two between 2 and 16. The bank depth must be a power of two of at least 2. Any other value stops elaboration with an error.

Top module: `rot_interleave_arb`

## Requirements
- R1: While rst_n is low, and after reset until a request arrives, every core_gnt and core_rvalid bit is 0.
- R2: The phase is 0 during reset and increases by one, modulo N, on every rising edge after reset. In each cycle core c faces bank (c + phase) mod N. The bank of a word address is its low log2(N) bits.
- R3: A held request is granted in the first cycle in which its core faces its bank. The number of cycles before the grant is therefore (bank - c - phase) mod N, where phase is the value in the cycle the request is first presented.
- R4: No held request waits more than N-1 cycles before its grant.
- R5: core_gnt is high only while core_req is high. If the core keeps the same request raised in the cycle after its grant, no second grant is given.
- R6: For a granted read, core_rvalid is high for exactly one cycle, the cycle after the grant, and core_rdata carries the word in that cycle. A granted write produces no core_rvalid.
- R7: Bit k of a core's byte enable governs data bits 8k+7 down to 8k of a write. A lane whose enable bit is 0 keeps its old content.
- R8: A write is seen by every read granted in a later cycle, whichever core issues that read.
- R9: The row within a bank is the word address shifted right by log2(N). All N x depth word addresses name separate storage.
- R10: Any number of cores, up to all N, are granted in the same cycle when each faces the bank of its own address. No two grants in one cycle ever fall on the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| core_req | input | NCORES | Per-core request, held until granted |
| core_we | input | NCORES | Per-core write flag (1 = write, 0 = read) |
| core_addr | input | NCORES*AW | Per-core word address, core c in bits [c*AW +: AW]; AW = log2(NCORES)+log2(BANK_DEPTH) |
| core_wdata | input | NCORES*DATA_W | Per-core write data |
| core_be | input | NCORES*DATA_W/8 | Per-core byte enables for writes |
| core_gnt | output | NCORES | One-cycle grant pulse per core |
| core_rvalid | output | NCORES | Read data valid, one cycle after a read grant |
| core_rdata | output | NCORES*DATA_W | Per-core read data |

## Verification
The bench takes four cores with sixteen rows per bank. Every core requests every address, and each measured wait is compared with the modular distance between the address's bank and the core's current bank. A phase that started anywhere but zero, or a bank taken from the wrong address bits, shifts these waits or returns another word. Each of the sixteen byte-enable patterns is written over a known word and read back, so a lane mask that is misplaced or inverted corrupts neighbouring bytes. Bursts in which all cores are aligned in the same cycle must grant every core at once and return each its own word. A crossbar that routes a bank to the wrong core, or that holds a request back, shows up as a missing grant or swapped data. Holding a request for a cycle after its grant catches a grant that is not a single pulse, and a valid strobe that lasts too long is caught in the same way.

// File: rtl/rot_pkg.sv
package rot_pkg;

    // Per-core access controller states
    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_WAIT = 2'd1,
        PORT_RESP = 2'd2
    } port_state_e;

endpackage

// File: rtl/rot_phase_counter.sv
module rot_phase_counter #(
    parameter  int NCORES = 4,
    localparam int LW     = $clog2(NCORES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [LW-1:0] phase
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R2: the rotation moves one bank per cycle, wrapping at N
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase == LW'($past(phase) + 1'b1)));

endmodule

// File: rtl/rot_bank_ram.sv
module rot_bank_ram #(
    parameter  int DEPTH  = 16,
    parameter  int DATA_W = 32,
    localparam int RW     = $clog2(DEPTH),
    localparam int BW     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [RW-1:0]     row,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BW-1:0]     be,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int k = 0; k < BW; k++) begin
                    if (be[k]) begin
                        mem[row][8*k +: 8] <= wdata[8*k +: 8];
                    end
                end
            end else begin
                rdata <= mem[row];
            end
        end
    end

endmodule

// File: rtl/rot_port_ctrl.sv
module rot_port_ctrl
    import rot_pkg::*;
#(
    parameter  int NCORES  = 4,
    parameter  int CORE_ID = 0,
    localparam int LW      = $clog2(NCORES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [LW-1:0] addr_bank,
    input  logic [LW-1:0] phase,
    output logic          gnt,
    output logic          rvalid,
    output logic [LW-1:0] sel_q
);

    port_state_e   state_q, state_d;
    logic [LW-1:0] facing;
    logic          aligned;
    logic [LW:0]   wait_q;

    // Bank this core faces in the current cycle
    always_comb begin
        facing  = LW'(CORE_ID) + phase;
        aligned = (facing == addr_bank);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE, PORT_RESP: begin
                if (req && aligned) begin
                    state_d = we ? PORT_IDLE : PORT_RESP;
                end else if (req) begin
                    state_d = PORT_WAIT;
                end else begin
                    state_d = PORT_IDLE;
                end
            end
            PORT_WAIT: begin
                if (!req) begin
                    state_d = PORT_IDLE;
                end else if (aligned) begin
                    state_d = we ? PORT_IDLE : PORT_RESP;
                end else begin
                    state_d = PORT_WAIT;
                end
            end
            default: state_d = PORT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        gnt    = req && aligned;
        rvalid = (state_q == PORT_RESP);
    end

    // Bank remembered for read return; wait length for the bound check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            wait_q <= '0;
        end else begin
            wait_q <= (req && !aligned) ? wait_q + 1'b1 : '0;
            if (req && aligned) begin
                sel_q <= facing;
            end
        end
    end

    // R4: a held request never waits more than N-1 cycles
    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |-> (int'(wait_q) < NCORES - 1));

    // R6: a read grant is followed by valid data in the next cycle
    assert_read_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !we) |=> rvalid);

    // R6: valid data only ever follows a read grant
    assert_rvalid_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(gnt && !we));

    // R6: a write grant returns nothing
    assert_write_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && we) |=> !rvalid);

endmodule

// File: rtl/rot_interleave_arb.sv
module rot_interleave_arb #(
    parameter  int NCORES     = 4,
    parameter  int BANK_DEPTH = 16,
    parameter  int DATA_W     = 32,
    localparam int LW         = $clog2(NCORES),
    localparam int RW         = $clog2(BANK_DEPTH),
    localparam int AW         = LW + RW,
    localparam int BW         = DATA_W / 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCORES-1:0]        core_req,
    input  logic [NCORES-1:0]        core_we,
    input  logic [NCORES*AW-1:0]     core_addr,
    input  logic [NCORES*DATA_W-1:0] core_wdata,
    input  logic [NCORES*BW-1:0]     core_be,
    output logic [NCORES-1:0]        core_gnt,
    output logic [NCORES-1:0]        core_rvalid,
    output logic [NCORES*DATA_W-1:0] core_rdata
);

    // Configuration guard: power-of-two core count in range, power-of-two depth
    if (((NCORES & (NCORES - 1)) != 0) || (NCORES < 2) || (NCORES > 16) ||
        ((BANK_DEPTH & (BANK_DEPTH - 1)) != 0) || (BANK_DEPTH < 2)) begin : g_bad_config
        $error("rot_interleave_arb: NCORES must be a power of two in 2..16 and BANK_DEPTH a power of two >= 2");
    end

    logic [LW-1:0]     phase;
    logic [NCORES-1:0] gnt_v;
    logic [LW-1:0]     bank_v  [NCORES];
    logic [RW-1:0]     row_v   [NCORES];
    logic [LW-1:0]     sel_v   [NCORES];
    logic [DATA_W-1:0] wdata_v [NCORES];
    logic [BW-1:0]     be_v    [NCORES];
    logic [DATA_W-1:0] bank_rd [NCORES];

    rot_phase_counter #(.NCORES(NCORES)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    // Per-core address split and access controller
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        assign bank_v[c]  = core_addr[c*AW +: LW];
        assign row_v[c]   = core_addr[c*AW+LW +: RW];
        assign wdata_v[c] = core_wdata[c*DATA_W +: DATA_W];
        assign be_v[c]    = core_be[c*BW +: BW];

        rot_port_ctrl #(.NCORES(NCORES), .CORE_ID(c)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (core_req[c]),
            .we        (core_we[c]),
            .addr_bank (bank_v[c]),
            .phase     (phase),
            .gnt       (gnt_v[c]),
            .rvalid    (core_rvalid[c]),
            .sel_q     (sel_v[c])
        );

        assign core_rdata[c*DATA_W +: DATA_W] = bank_rd[sel_v[c]];
    end

    assign core_gnt = gnt_v;

    // Per-bank crossbar leg: bank b is faced by core (b - phase) mod N
    for (genvar b = 0; b < NCORES; b++) begin : g_bank
        logic [LW-1:0]     src;
        logic              en;
        logic              we;
        logic [RW-1:0]     row;
        logic [DATA_W-1:0] wdata;
        logic [BW-1:0]     be;

        always_comb begin
            src   = LW'(b) - phase;
            en    = gnt_v[src];
            we    = core_we[src];
            row   = row_v[src];
            wdata = wdata_v[src];
            be    = be_v[src];
        end

        rot_bank_ram #(.DEPTH(BANK_DEPTH), .DATA_W(DATA_W)) u_ram (
            .clk   (clk),
            .en    (en),
            .we    (we),
            .row   (row),
            .wdata (wdata),
            .be    (be),
            .rdata (bank_rd[b])
        );
    end

    // R10: grants in one cycle never share a bank
    for (genvar i = 0; i < NCORES; i++) begin : g_pair_i
        for (genvar j = i + 1; j < NCORES; j++) begin : g_pair_j
            assert_distinct_banks_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !(gnt_v[i] && gnt_v[j] && (bank_v[i] == bank_v[j])));
        end
    end

endmodule

// File: tb/tb_rot_interleave_arb.sv
`timescale 1ns/1ps
module tb_rot_interleave_arb;

    localparam int N  = 4;
    localparam int D  = 16;
    localparam int DW = 32;
    localparam int LW = 2;
    localparam int AW = 6;
    localparam int BW = 4;
    localparam int NW = N * D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      core_req = '0;
    logic [N-1:0]      core_we = '0;
    logic [N*AW-1:0]   core_addr = '0;
    logic [N*DW-1:0]   core_wdata = '0;
    logic [N*BW-1:0]   core_be = '0;
    logic [N-1:0]      core_gnt;
    logic [N-1:0]      core_rvalid;
    logic [N*DW-1:0]   core_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;
    logic [DW-1:0] model [NW];

    rot_interleave_arb #(.NCORES(N), .BANK_DEPTH(D), .DATA_W(DW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_req    (core_req),
        .core_we     (core_we),
        .core_addr   (core_addr),
        .core_wdata  (core_wdata),
        .core_be     (core_be),
        .core_gnt    (core_gnt),
        .core_rvalid (core_rvalid),
        .core_rdata  (core_rdata)
    );

    always #2.5 clk = ~clk;

    // Phase reference: 0 in reset, one step per edge afterwards (R2)
    always @(posedge clk) if (rst_n) cyc = cyc + 1;

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic [BW-1:0] be);
        logic [DW-1:0] r = old;
        for (int k = 0; k < BW; k++) if (be[k]) r[8*k +: 8] = d[8*k +: 8];
        return r;
    endfunction

    // One access from one core, with wait, pulse and return checks
    task automatic access(int c, bit w, int a, logic [DW-1:0] d, logic [BW-1:0] be, string tag);
        int exp_wait;
        int waited;
        @(negedge clk);
        core_req[c] = 1'b1;
        core_we[c]  = w;
        core_addr[c*AW +: AW]  = AW'(a);
        core_wdata[c*DW +: DW] = d;
        core_be[c*BW +: BW]    = be;
        exp_wait = (((a % N) - c - (cyc % N)) % N + N) % N;
        waited = 0;
        #1;
        while (!core_gnt[c] && waited < 2*N) begin
            @(negedge clk); #1;
            waited++;
        end
        check(waited == exp_wait, "R2 R3 wait", waited, exp_wait);
        check(waited <= N-1, "R4 bound", waited, N-1);
        if (w) model[a] = merge(model[a], d, be);
        @(negedge clk); #1;
        check(core_gnt[c] == 1'b0, "R5 single pulse", core_gnt[c], 0);
        if (w) begin
            check(core_rvalid[c] == 1'b0, "R6 no write return", core_rvalid[c], 0);
        end else begin
            check(core_rvalid[c] == 1'b1, "R6 rvalid", core_rvalid[c], 1);
            check(core_rdata[c*DW +: DW] === model[a], tag, core_rdata[c*DW +: DW], model[a]);
        end
        core_req[c] = 1'b0;
        @(negedge clk); #1;
        check(core_rvalid[c] == 1'b0, "R6 one cycle", core_rvalid[c], 0);
        check(core_gnt[c] == 1'b0, "R5 no req", core_gnt[c], 0);
    endtask

    // All cores aligned in the same cycle, same row, distinct banks
    task automatic burst(bit w, int row, logic [DW-1:0] seed);
        int ph;
        int a [N];
        @(negedge clk);
        ph = cyc % N;
        for (int c = 0; c < N; c++) begin
            a[c] = row*N + (c + ph) % N;
            core_req[c] = 1'b1;
            core_we[c]  = w;
            core_addr[c*AW +: AW]  = AW'(a[c]);
            core_wdata[c*DW +: DW] = seed ^ DW'(c * 32'h0101_0101);
            core_be[c*BW +: BW]    = '1;
        end
        #1;
        for (int c = 0; c < N; c++) begin
            check(core_gnt[c] == 1'b1, "R10 joint grant", core_gnt[c], 1);
            if (w) model[a[c]] = seed ^ DW'(c * 32'h0101_0101);
        end
        @(negedge clk); #1;
        for (int c = 0; c < N; c++) begin
            if (!w) begin
                check(core_rvalid[c] == 1'b1, "R10 joint rvalid", core_rvalid[c], 1);
                check(core_rdata[c*DW +: DW] === model[a[c]], "R10 joint data",
                      core_rdata[c*DW +: DW], model[a[c]]);
            end
        end
        core_req = '0;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(core_gnt == '0, "R1 reset gnt", core_gnt, 0);
        check(core_rvalid == '0, "R1 reset rvalid", core_rvalid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(core_gnt == '0, "R1 idle gnt", core_gnt, 0);
        @(negedge clk); #1;
        check(core_rvalid == '0, "R1 idle rvalid", core_rvalid, 0);

        // R9: fill every address with a distinct word
        for (int a = 0; a < NW; a++)
            access((a * 3) % N, 1'b1, a, 32'hA500_0000 ^ DW'(a * 32'h0001_0203), '1, "R9 fill");

        // R8 R9: every core reads every address
        for (int c = 0; c < N; c++)
            for (int a = 0; a < NW; a++)
                access(c, 1'b0, a, '0, '0, "R8 R9 sweep data");

        // R7: all byte-enable patterns over a known word
        for (int be = 0; be < 16; be++) begin
            access(be % N, 1'b1, 21, 32'h0000_0000, '1, "R7 clear");
            access((be + 1) % N, 1'b1, 21, 32'hAABB_CCDD, BW'(be), "R7 lanes");
            access((be + 2) % N, 1'b0, 21, '0, '0, "R7 lanes data");
        end
        access(0, 1'b1, 37, 32'h0000_0000, '1, "R7 clear");
        access(1, 1'b1, 37, 32'hAABB_CCDD, 4'b0101, "R7 lanes");
        @(negedge clk);
        check(model[37] == 32'h00BB_00DD, "R7 fixed pattern", model[37], 32'h00BB_00DD);
        access(2, 1'b0, 37, '0, '0, "R7 fixed data");

        // R10: joint writes then joint reads on several rows
        for (int r = 0; r < D; r += 5) begin
            burst(1'b1, r, 32'h5A5A_0000 + DW'(r));
            burst(1'b0, r, '0);
        end
        // R8: cross-core visibility after joint writes
        for (int c = 0; c < N; c++) access((c + 1) % N, 1'b0, 5*N + c, '0, '0, "R8 cross core");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule